// File: doc/BRIEF.md
# Serial Register Access Port

This block is a serial slave that gives an external master write and read access to a small bank of 8-bit registers. The master drives an active-low chip select, a serial clock and a serial data input. The block returns read data on a serial output with its own drive enable, and a pad elsewhere in the chip turns that enable into a high-impedance state. On the chip side, control registers drive configuration outputs to the logic they steer. Status flags from that logic are latched into read-to-clear registers, and an active-low interrupt reports latched flags that have been enabled.

Every access is one fixed frame of sixteen serial clocks that addresses one register. The first bit is the direction. Six address bits follow, lowest first, then one bit that is ignored, then eight data bits, lowest first. A write takes effect only when the sixteenth bit has been taken in. A read returns the addressed byte, lowest bit first, during the last eight clocks. Bursts are not supported, so chip select must be released between accesses. The serial pins are sampled in the block's own clock domain through synchronizers. The serial clock must therefore stay high and low for at least four system clocks in each phase.

Top module: `serial_reg_port`

## Requirements
- R1: Serial data is taken on rising edges of the serial clock while chip select is low. Frame bit 1 is the direction (1 = read, 0 = write). Bits 2 to 7 are address bits A0..A5. Bit 8 is ignored. Bits 9 to 16 are data bits D0..D7.
- R2: A write frame updates a control register (addresses 0 to NUM_CTRL-1) or an interrupt enable register (IEN_BASE+i) only after the 16th rising edge. `ctrl_out[8*k+7:8*k]` shows control register k.
- R3: If chip select rises before the 16th rising edge, the frame is discarded and no register changes.
- R4: `sdo_oe` is low at all times except during a read data phase. After the falling edges that follow rising edges 8 to 15 of a read, `sdo` carries D0 to D7 of the addressed register in that order. `sdo_oe` drops after the falling edge that follows the 16th rising edge.
- R5: While `rst_n` is low, the control registers hold CTRL_RST (byte k at bits 8k+7:8k), and the status latches and interrupt enables hold zero.
- R6: A high bit on `stat_in` sets the matching bit of status latch i (address STAT_BASE+i, bits 8i+7:8i of `stat_in`). A completed read of that address clears the bits it returned. A flag that is still high at that moment stays set.
- R7: Writes to status latch addresses and to unimplemented addresses change nothing. Reads of unimplemented addresses return 0x00.
- R8: `irq_n` is low exactly when some latched status bit is set and its matching enable bit is set.
- R9: Serial clocks after the 16th, before chip select rises, are ignored. They cause no second write and do not drive `sdo_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset to defaults |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Drive enable for the serial output pad |
| ctrl_out | output | NUM_CTRL*8 | Control register contents |
| stat_in | input | NUM_STAT*8 | Status flags from the controlled logic |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The bench builds the block with four control registers, two status and enable pairs, status at 0x20 and enables at 0x28, and two synchronizer stages. With this configuration every one of the 64 addresses can be written and then read back against an arithmetic model, so both decode branches and the zero return of unimplemented locations are covered. The small bank also makes it possible to test directly the read-clear race, with a flag held high during its own read, and the enable masking of the interrupt. Short frames of 9 and 15 bits, a 20-bit frame and a reset in the middle of a run check the commit boundary.

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
  parameter int NUM_CTRL = 4,
  parameter int NUM_STAT = 2,
  parameter logic [5:0] STAT_BASE = 6'h20,
  parameter logic [5:0] IEN_BASE = 6'h28,
  parameter logic [NUM_CTRL*8-1:0] CTRL_RST = 32'h0F00815A,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  sclk,
  input  logic                  sdi,
  output logic                  sdo,
  output logic                  sdo_oe,
  output logic [NUM_CTRL*8-1:0] ctrl_out,
  input  logic [NUM_STAT*8-1:0] stat_in,
  output logic                  irq_n
);
  localparam int LAST = 15;
  localparam int DONE = 16;

  logic [SYNC_STAGES-1:0] cs_sy, ck_sy, di_sy;
  logic cs_s, ck_s, di_s, ck_d;
  logic ck_rise, ck_fall;
  logic [4:0] cnt;
  logic rw;
  logic [5:0] addr;
  logic [7:0] wsr, txb, rd_byte, wr_data;
  logic last_bit, commit_wr, done_rd;
  logic [NUM_STAT*8-1:0] lat_flat, ien_flat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sy <= '1;
      ck_sy <= '0;
      di_sy <= '0;
      ck_d  <= 1'b0;
    end else begin
      cs_sy <= {cs_sy[SYNC_STAGES-2:0], cs_n};
      ck_sy <= {ck_sy[SYNC_STAGES-2:0], sclk};
      di_sy <= {di_sy[SYNC_STAGES-2:0], sdi};
      ck_d  <= ck_s;
    end

  assign cs_s = cs_sy[SYNC_STAGES-1];
  assign ck_s = ck_sy[SYNC_STAGES-1];
  assign di_s = di_sy[SYNC_STAGES-1];
  assign ck_rise = ck_s & ~ck_d & ~cs_s;
  assign ck_fall = ~ck_s & ck_d & ~cs_s;

  assign last_bit  = ck_rise && cnt == 5'(LAST);
  assign commit_wr = last_bit && !rw;
  assign done_rd   = last_bit && rw;
  assign wr_data   = {di_s, wsr[7:1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt  <= '0;
      rw   <= 1'b0;
      addr <= '0;
      wsr  <= '0;
      txb  <= '0;
    end else if (cs_s) begin
      cnt <= '0;
    end else if (ck_rise && cnt != 5'(DONE)) begin
      cnt <= cnt + 5'd1;
      if (cnt == 5'd0) rw <= di_s;
      if (cnt >= 5'd1 && cnt <= 5'd6) addr <= {di_s, addr[5:1]};
      if (cnt == 5'd7) txb <= rd_byte;
      if (cnt >= 5'd8) wsr <= wr_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sdo_oe <= 1'b0;
      sdo    <= 1'b0;
    end else if (cs_s) begin
      sdo_oe <= 1'b0;
    end else if (ck_fall) begin
      if (rw && cnt >= 5'd8 && cnt <= 5'(LAST)) begin
        sdo_oe <= 1'b1;
        sdo    <= txb[cnt[2:0]];
      end else begin
        sdo_oe <= 1'b0;
      end
    end

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
    logic [7:0] r;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) r <= CTRL_RST[g*8 +: 8];
      else if (commit_wr && addr == 6'(g)) r <= wr_data;
    assign ctrl_out[g*8 +: 8] = r;
  end

  for (genvar g = 0; g < NUM_STAT; g++) begin : g_stat
    logic [7:0] lat, ien;
    logic clr;
    assign clr = done_rd && addr == STAT_BASE + 6'(g);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        lat <= '0;
        ien <= '0;
      end else begin
        lat <= (lat & ~(clr ? txb : 8'h00)) | stat_in[g*8 +: 8];
        if (commit_wr && addr == IEN_BASE + 6'(g)) ien <= wr_data;
      end
    assign lat_flat[g*8 +: 8] = lat;
    assign ien_flat[g*8 +: 8] = ien;
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NUM_CTRL; i++)
      if (addr == 6'(i)) rd_byte = ctrl_out[i*8 +: 8];
    for (int i = 0; i < NUM_STAT; i++) begin
      if (addr == STAT_BASE + 6'(i)) rd_byte = lat_flat[i*8 +: 8];
      if (addr == IEN_BASE + 6'(i)) rd_byte = ien_flat[i*8 +: 8];
    end
  end

  assign irq_n = ~|(lat_flat & ien_flat);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 5'(DONE)); // R9
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !sdo_oe); // R4
  AST_OE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !rw |-> !sdo_oe); // R1
  AST_OE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> cnt == 5'd8); // R4
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_wr |=> $stable(ctrl_out)); // R3
  AST_LAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !done_rd |=> ((lat_flat & $past(lat_flat)) == $past(lat_flat))); // R6
endmodule

// File: tb/sim_serial_reg_port.sv
module sim_serial_reg_port;
  localparam int HALF = 4;
  localparam logic [5:0] SB = 6'h20;
  localparam logic [5:0] IB = 6'h28;

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, sdi = 0;
  logic sdo, sdo_oe, irq_n;
  logic [31:0] ctrl_out;
  logic [15:0] stat_in = '0;
  int ncmp = 0, nerr = 0;
  bit finished = 0;
  logic [7:0] ctrl_m [4];
  logic [7:0] ien_m [2];
  logic [7:0] lat_m [2];

  always #5 clk = ~clk;

  serial_reg_port #(.NUM_CTRL(4), .NUM_STAT(2), .STAT_BASE(SB), .IEN_BASE(IB),
                    .CTRL_RST(32'h0F00815A), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .sdo_oe(sdo_oe), .ctrl_out(ctrl_out), .stat_in(stat_in), .irq_n(irq_n));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    ctrl_m[0] = 8'h5A; ctrl_m[1] = 8'h81; ctrl_m[2] = 8'h00; ctrl_m[3] = 8'h0F;
    for (int i = 0; i < 2; i++) begin ien_m[i] = 0; lat_m[i] = 0; end
  endtask

  function automatic logic [7:0] exp_rd(input logic [5:0] a);
    if (a < 6'd4) return ctrl_m[a[1:0]];
    if (a == SB || a == SB + 6'd1) return lat_m[a[0]];
    if (a == IB || a == IB + 6'd1) return ien_m[a[0]];
    return 8'h00;
  endfunction

  task automatic set_stat(input logic [15:0] v);
    @(negedge clk);
    stat_in = v;
    lat_m[0] |= v[7:0];
    lat_m[1] |= v[15:8];
    repeat (4) @(negedge clk);
  endtask

  task automatic frame(input bit rd, input logic [5:0] a, input logic [7:0] d,
                       input int nb, output logic [7:0] q);
    logic [19:0] bits;
    bits = {4'hF, d, 1'b0, a, rd};
    q = '0;
    @(negedge clk);
    cs_n = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      sdi = bits[i];
      repeat (HALF) @(negedge clk);
      if (rd && i >= 8 && i < 16) begin
        q[i-8] = sdo;
        chk("R4 oe in data phase", 32'(sdo_oe), 32'd1);
      end else begin
        chk(i >= 16 ? "R9 oe after 16 bits" : "R4 oe outside data phase", 32'(sdo_oe), 32'd0);
      end
      sclk = 1;
      repeat (HALF) @(negedge clk);
      sclk = 0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1;
    repeat (6) @(negedge clk);
    chk("R4 oe after frame", 32'(sdo_oe), 32'd0);
    if (nb >= 16) begin
      if (!rd) begin
        if (a < 6'd4) ctrl_m[a[1:0]] = d;
        if (a == IB || a == IB + 6'd1) ien_m[a[0]] = d;
      end else if (a == SB || a == SB + 6'd1) begin
        lat_m[a[0]] = (lat_m[a[0]] & ~q) | (a[0] ? stat_in[15:8] : stat_in[7:0]);
      end
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    logic [7:0] q;
    frame(0, a, d, 16, q);
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a);
    logic [7:0] q, e;
    e = exp_rd(a);
    frame(1, a, 8'h00, 16, q);
    chk(tag, 32'(q), 32'(e));
  endtask

  function automatic logic [31:0] ctrl_exp();
    return {ctrl_m[3], ctrl_m[2], ctrl_m[1], ctrl_m[0]};
  endfunction

  function automatic logic irq_exp();
    return ~|((lat_m[0] & ien_m[0]) | (lat_m[1] & ien_m[1]));
  endfunction

  initial begin
    logic [7:0] q;
    model_reset();
    repeat (5) @(negedge clk);
    chk("R5 ctrl default in reset", ctrl_out, 32'h0F00815A);
    chk("R5 irq idle in reset", 32'(irq_n), 32'd1);
    chk("R4 oe idle in reset", 32'(sdo_oe), 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    rd_chk("R5 ctrl0 default read", 6'd0);
    rd_chk("R5 ctrl3 default read", 6'd3);
    rd_chk("R5 status default read", SB);
    rd_chk("R5 enable default read", IB + 6'd1);

    for (int a = 0; a < 64; a++) wr(6'(a), 8'((a * 37 + 11) & 255));
    chk("R2 ctrl after sweep", ctrl_out, ctrl_exp());
    for (int a = 0; a < 64; a++) rd_chk("R1 R7 sweep readback", 6'(a));
    chk("R8 irq after sweep", 32'(irq_n), 32'(irq_exp()));

    frame(0, 6'd1, 8'h77, 15, q);
    chk("R3 15-bit frame discarded", ctrl_out, ctrl_exp());
    frame(0, 6'd2, 8'h66, 9, q);
    chk("R3 9-bit frame discarded", ctrl_out, ctrl_exp());
    frame(1, SB, 8'h00, 15, q);
    frame(0, 6'd2, 8'h33, 20, q);
    chk("R9 extra clocks ignored", ctrl_out, ctrl_exp());
    chk("R9 ctrl2 value", 32'(ctrl_out[23:16]), 32'h33);

    wr(IB, 8'h00);
    wr(IB + 6'd1, 8'h00);
    set_stat(16'h3CA5);
    set_stat(16'h0000);
    chk("R8 irq masked", 32'(irq_n), 32'd1);
    wr(SB, 8'hFF);
    rd_chk("R7 R6 status write ignored", SB);
    rd_chk("R6 status cleared by read", SB);
    set_stat(16'h0100);
    rd_chk("R6 status1 with held flag", SB + 6'd1);
    rd_chk("R6 held flag stays set", SB + 6'd1);
    set_stat(16'h0000);
    rd_chk("R6 last latched value", SB + 6'd1);
    rd_chk("R6 clear after release", SB + 6'd1);

    set_stat(16'h0001);
    set_stat(16'h0000);
    chk("R8 irq masked by zero enable", 32'(irq_n), 32'd1);
    wr(IB, 8'h01);
    chk("R8 irq asserted", 32'(irq_n), 32'd0);
    chk("R8 irq vs model", 32'(irq_n), 32'(irq_exp()));
    wr(IB, 8'hFE);
    chk("R8 irq masked by other enables", 32'(irq_n), 32'd1);
    wr(IB, 8'h01);
    rd_chk("R6 read clears flag", SB);
    chk("R8 irq released by read", 32'(irq_n), 32'd1);

    wr(6'd0, 8'hC3);
    set_stat(16'h8000);
    @(negedge clk);
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R5 ctrl after mid reset", ctrl_out, 32'h0F00815A);
    rst_n = 1;
    set_stat(16'h0000);
    lat_m[1] = 8'h80;
    rd_chk("R5 enable cleared by reset", IB);
    rd_chk("R6 flag relatched after reset", SB + 6'd1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      ncmp++;
      nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
      $finish;
    end
  end
endmodule